// File: doc/BRIEF.md
# Serial-Bus EEPROM Slave Controller

This block is the digital core of a two-wire serial memory. It watches the SCL and SDA lines from the pads, recognises bus conditions, and answers a fixed device address. Behind it is a 256-byte store built from a register array. A host can write a single byte or a run of up to sixteen bytes into one 16-byte page. It can read from wherever the internal pointer stands, from an address it chooses, or in a continuous stream. SDA is driven as an open-drain line: the block only ever asserts a pull-low enable. The pad and the external pull-up form the wired line.

After a write ends with a STOP, the block runs an internal write cycle. This cycle lasts a fixed number of system clocks. The buffered page bytes land in the array when the cycle finishes. While the cycle runs, the device does not acknowledge its own address, so the host can poll for completion. A supervisory reset-inhibit input stops all bus activity. A write cycle that has already started is always allowed to finish.

The serial bus has no stall mechanism: the block never stretches SCL. It therefore neither offers nor accepts back-pressure. All pins are plain control and status lines, not valid/ready streams.

Top module: `seeprom_i2c_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Before the first START the block ignores the bus. A START or STOP in the middle of a byte sends the block back to receiving a device address.
- R2: The device address byte is seven bits, 1010000 by default (parameter), followed by a direction bit: 1 means read, 0 means write. On a match the block pulls SDA low in the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next START.
- R3: In a write transfer, the byte that follows the address loads the 8-bit pointer. The block acknowledges that byte and every data byte in the ninth clock.
- R4: Each data byte goes into a 16-entry page buffer at the pointer's low four bits. Only those four bits then increment, wrapping within the page, so a seventeenth byte overwrites the first. The upper four bits do not change.
- R5: An internal write cycle starts only on a STOP that closes a write carrying at least one data byte. A write with no data byte, or one cut off by a repeated START, changes no memory and does not set busy.
- R6: `busy` stays high for exactly WR_CYCLES clocks. The buffered bytes appear in memory at its end. While busy is high, the device address gets no acknowledge.
- R7: A read with no address phase returns the byte at the last accessed address plus one. The pointer wraps from 255 to 0.
- R8: A write that carries only the pointer byte, followed by a repeated START with the read bit set, returns the byte at that pointer.
- R9: During a read, a master ACK after a byte brings the next byte, with all eight pointer bits incrementing. A master NACK makes the block release SDA and wait for a START or STOP.
- R10: While `hold` is high, any transfer is abandoned, SDA is released, no address is acknowledged and no write cycle starts. A write cycle that is already running completes and updates memory.
- R11: `sda_oe` changes only while the synchronised SCL is low, except when `hold` forces it off.
- R12: After reset, `sda_oe` and `busy` are low, the pointer is 0 and every memory byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus is oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired value) |
| hold | input | 1 | Supervisory reset-inhibit, active high |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Four kinds of checks run on every clock:
- the pull-down enable moves only while the synchronised clock is low, unless `hold` forces it off;
- the line is never pulled while a write cycle is running;
- a write cycle starts only on the clock after a STOP, and never when `hold` was high;
- each busy period lasts exactly the programmed number of cycles.

Only the bench scenarios can show the data path. These cover:
- page wrap-around and last-byte-wins overwrite;
- the pointer after writes and after streamed reads, including 255 to 0;
- dummy writes and writes aborted by a START leaving memory unchanged;
- recovery from a START in the middle of a byte;
- a write cycle finishing its memory update even while `hold` is asserted.

// File: rtl/seeprom_pkg.sv
`timescale 1ns/1ps
package seeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_DEV,    // shifting in device address
    ST_WADDR,  // shifting in pointer byte
    ST_WDATA,  // shifting in data bytes
    ST_ACK,    // driving the ninth-clock acknowledge
    ST_TX,     // shifting out a read byte
    ST_RACK,   // sampling master acknowledge
    ST_WAIT    // parked until START or STOP
  } link_st_t;
endpackage

// File: rtl/seeprom_bus_sense.sv
`timescale 1ns/1ps
module seeprom_bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_sh, sda_sh;
  logic          scl_q, sda_q;

  // Lines idle high, so the chain resets to ones and no edge appears at reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_in};
      sda_sh <= {sda_sh[LAST-1:0], sda_in};
      scl_q  <= scl_sh[LAST];
      sda_q  <= sda_sh[LAST];
    end
  end

  assign scl_s     = scl_sh[LAST];
  assign sda_s     = sda_sh[LAST];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/seeprom_wr_timer.sv
`timescale 1ns/1ps
module seeprom_wr_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      left <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end
  end

  // Last busy cycle: the commit happens on this edge, independent of any bus reset.
  assign finish = busy && (left == '0);
endmodule

// File: rtl/seeprom_store.sv
`timescale 1ns/1ps
module seeprom_store #(
  parameter int AW = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          buf_we,
  input  logic [PW-1:0] buf_idx,
  input  logic [7:0]    buf_data,
  input  logic          discard,
  input  logic          commit,
  input  logic [AW-PW-1:0] page
);
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = 1 << PW;

  logic [7:0]       mem    [DEPTH];
  logic [7:0]       slot_d [SLOTS];
  logic [SLOTS-1:0] slot_v;
  logic [SLOTS-1:0] slot_hit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_hit[g] = buf_we && (buf_idx == PW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= '0;
      for (int i = 0; i < SLOTS; i++) slot_d[i] <= '0;
    end else if (discard || commit) begin
      slot_v <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (slot_hit[i]) begin
          slot_d[i] <= buf_data;
          slot_v[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < SLOTS; i++)
        if (slot_v[i]) mem[{page, PW'(i)}] <= slot_d[i];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/seeprom_i2c_slave.sv
`timescale 1ns/1ps
module seeprom_i2c_slave
  import seeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         WR_CYCLES   = 5000,
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic hold,
  output logic sda_oe,
  output logic busy
);
  localparam int BIT_LAST = 7;
  localparam int BIT_DONE = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  seeprom_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  link_st_t          st, nxt;
  logic [3:0]        bcnt;
  logic [7:0]        sr;
  logic              ack_drv, rack_seen, rack_ok, has_data, oe_q;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rx_byte, rd_data;
  logic              quiet, buf_we, discard, wr_go, wr_finish;

  assign rx_byte = {sr[6:0], sda_s};
  assign quiet   = !hold && !start_det && !stop_det;
  assign buf_we  = quiet && (st == ST_WDATA) && scl_rise && (bcnt == 4'(BIT_LAST));
  // The page buffer must survive ACK polling, so START clears it only when idle.
  assign discard = (hold || start_det) && !busy;
  assign wr_go   = !hold && stop_det && has_data;

  seeprom_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_go), .busy(busy), .finish(wr_finish)
  );

  seeprom_store #(.AW(ADDR_W), .PW(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(ptr), .rd_data(rd_data),
    .buf_we(buf_we), .buf_idx(ptr[PAGE_W-1:0]), .buf_data(rx_byte),
    .discard(discard), .commit(wr_finish), .page(ptr[ADDR_W-1:PAGE_W])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      nxt       <= ST_IDLE;
      bcnt      <= '0;
      sr        <= '0;
      ack_drv   <= 1'b0;
      rack_seen <= 1'b0;
      rack_ok   <= 1'b0;
      has_data  <= 1'b0;
      oe_q      <= 1'b0;
      ptr       <= '0;
    end else if (hold) begin
      st       <= ST_IDLE;
      oe_q     <= 1'b0;
      ack_drv  <= 1'b0;
      has_data <= 1'b0;
    end else if (start_det) begin
      st       <= ST_DEV;
      bcnt     <= '0;
      oe_q     <= 1'b0;
      ack_drv  <= 1'b0;
      has_data <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      oe_q     <= 1'b0;
      ack_drv  <= 1'b0;
      has_data <= 1'b0;
    end else begin
      unique case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            sr   <= rx_byte;
            bcnt <= bcnt + 1'b1;
            if (bcnt == 4'(BIT_LAST)) begin
              if (st == ST_DEV) begin
                if (rx_byte[7:1] == DEV_ADDR && !busy) begin
                  st  <= ST_ACK;
                  nxt <= rx_byte[0] ? ST_TX : ST_WADDR;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_WADDR) begin
                ptr <= rx_byte;
                st  <= ST_ACK;
                nxt <= ST_WDATA;
              end else begin
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                has_data        <= 1'b1;
                st              <= ST_ACK;
                nxt             <= ST_WDATA;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_drv) begin
              ack_drv <= 1'b1;
              oe_q    <= 1'b1;
            end else begin
              ack_drv <= 1'b0;
              bcnt    <= '0;
              st      <= nxt;
              if (nxt == ST_TX) begin
                sr   <= rd_data;
                oe_q <= ~rd_data[7];
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bcnt <= bcnt + 1'b1;
          end else if (scl_fall) begin
            if (bcnt == 4'(BIT_DONE)) begin
              st        <= ST_RACK;
              oe_q      <= 1'b0;
              ptr       <= ptr + 1'b1;
              rack_seen <= 1'b0;
            end else begin
              sr   <= {sr[6:0], 1'b0};
              oe_q <= ~sr[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            rack_seen <= 1'b1;
            rack_ok   <= ~sda_s;
          end else if (scl_fall && rack_seen) begin
            if (rack_ok) begin
              sr   <= rd_data;
              oe_q <= ~rd_data[7];
              bcnt <= '0;
              st   <= ST_TX;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/seeprom_i2c_checker.sv
`timescale 1ns/1ps
module seeprom_i2c_checker #(
  parameter int WR_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic busy,
  input logic sda_oe,
  input logic scl_s,
  input logic stop_det
);
  localparam int CW = $clog2(WR_CYCLES + 1) + 1;

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  assert_oe_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(hold)));

  assert_no_pull_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  assert_cycle_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == CW'(WR_CYCLES)));

  assert_hold_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !sda_oe);

  assert_hold_blocks_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(hold));
endmodule

bind seeprom_i2c_slave seeprom_i2c_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .busy(busy), .sda_oe(sda_oe),
  .scl_s(scl_s), .stop_det(stop_det)
);

// File: tb/seeprom_i2c_slave_test.sv
`timescale 1ns/1ps
module seeprom_i2c_slave_test;
  localparam int         W    = 600;
  localparam int         Q    = 8;
  localparam logic [7:0] DEVW = 8'hA0;
  localparam logic [7:0] DEVR = 8'hA1;

  // {write, address, data}
  localparam logic [16:0] VECS [8] = '{
    {1'b1, 8'h10, 8'h3C}, {1'b1, 8'h11, 8'hC3}, {1'b1, 8'hFF, 8'h81}, {1'b1, 8'h00, 8'h42},
    {1'b0, 8'h10, 8'h3C}, {1'b0, 8'h11, 8'hC3}, {1'b0, 8'hFF, 8'h81}, {1'b0, 8'h00, 8'h42}
  };

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, hold = 0;
  logic sda_oe, busy;
  wire  sda_bus = sda_m & ~sda_oe;
  int   n_chk = 0, n_fail = 0, cur_len = 0, last_len = 0;
  logic [7:0] pexp [16];

  always #2 clk = ~clk;

  seeprom_i2c_slave #(.WR_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .hold(hold), .sda_oe(sda_oe), .busy(busy)
  );

  always @(posedge clk) begin
    if (busy) cur_len <= cur_len + 1;
    else if (cur_len != 0) begin
      last_len <= cur_len;
      cur_len  <= 0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic tx_bit(input logic b);
    sda_m = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
  endtask

  task automatic rx_bit(output logic b);
    sda_m = 1; tick(Q); scl = 1; tick(Q); b = sda_bus; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic tx_byte(input logic [7:0] d, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) tx_bit(d[i]);
    rx_bit(x);
    ack = !x;
  endtask

  task automatic rx_byte(output logic [7:0] d, input bit mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      rx_bit(x);
      d[i] = x;
    end
    tx_bit(!mack);
  endtask

  task automatic wait_ready;
    tick(4);
    for (int i = 0; i < 4*W && busy; i++) tick(1);
  endtask

  task automatic write_one(input logic [7:0] a, input logic [7:0] d, output bit ok);
    bit k;
    bus_start;
    tx_byte(DEVW, k); ok = k;
    tx_byte(a, k);    ok &= k;
    tx_byte(d, k);    ok &= k;
    bus_stop;
    wait_ready;
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    bit k;
    bus_start; tx_byte(DEVW, k); tx_byte(a, k);
    bus_start; tx_byte(DEVR, k);
    rx_byte(d, 1'b0);
    bus_stop;
  endtask

  task automatic cur_read(output logic [7:0] d);
    bit k;
    bus_start; tx_byte(DEVR, k);
    rx_byte(d, 1'b0);
    bus_stop;
  endtask

  initial begin
    bit k, ok;
    logic [7:0] d;
    tick(5);
    rst_n = 1;
    tick(3);
    chk(sda_oe == 0, "R12 sda_oe after reset", sda_oe, 0);
    chk(busy == 0, "R12 busy after reset", busy, 0);

    // R1: a matching address byte without any START is ignored
    scl = 0; tick(Q);
    tx_byte(DEVW, k);
    sda_m = 1; tick(Q); scl = 1; tick(Q);
    chk(!k, "R1 no response before START", k, 0);

    cur_read(d);
    chk(d == 8'h00, "R12 memory and pointer zero after reset", d, 0);

    // vector table: writes then random reads (R3 R8 R11)
    for (int v = 0; v < 8; v++) begin
      if (VECS[v][16]) begin
        write_one(VECS[v][15:8], VECS[v][7:0], ok);
        chk(ok, "R3 R11 acks on address, pointer and data", ok, 1);
      end else begin
        rand_read(VECS[v][15:8], d);
        chk(d == VECS[v][7:0], "R8 random read", d, VECS[v][7:0]);
      end
    end

    // R9 / R7: stream across 255 -> 0
    bus_start; tx_byte(DEVW, k); tx_byte(8'hFF, k);
    bus_start; tx_byte(DEVR, k);
    rx_byte(d, 1'b1);
    chk(d == 8'h81, "R9 first streamed byte", d, 8'h81);
    rx_byte(d, 1'b0);
    chk(d == 8'h42, "R9 R7 pointer wraps 255 to 0", d, 8'h42);
    tick(2);
    chk(sda_oe == 0, "R9 released after master NACK", sda_oe, 0);
    bus_stop;
    cur_read(d);
    chk(d == 8'h00, "R7 current read after stream", d, 0);

    // R4: 17 bytes from 0x25 wrap inside page 0x20
    for (int i = 0; i < 17; i++) pexp[(5 + i) % 16] = 8'hA0 + 8'(i);
    bus_start; tx_byte(DEVW, k); ok = k; tx_byte(8'h25, k); ok &= k;
    for (int i = 0; i < 17; i++) begin
      tx_byte(8'hA0 + 8'(i), k);
      ok &= k;
    end
    bus_stop;
    chk(ok, "R3 R4 every page byte acknowledged", ok, 1);
    bus_start; tx_byte(DEVW, k); bus_stop;
    chk(!k, "R6 address not acknowledged while busy", k, 0);
    wait_ready;
    chk(last_len == W, "R6 busy length", last_len, W);
    bus_start; tx_byte(DEVW, k); bus_stop;
    chk(k, "R6 address acknowledged after cycle", k, 1);
    tick(8);
    chk(busy == 0, "R5 poll without data starts no cycle", busy, 0);
    cur_read(d);
    chk(d == 8'hA1, "R7 current read after page write", d, 8'hA1);
    bus_start; tx_byte(DEVW, k); tx_byte(8'h20, k);
    bus_start; tx_byte(DEVR, k);
    for (int j = 0; j < 16; j++) begin
      rx_byte(d, j < 15);
      chk(d == pexp[j], "R4 page wrap contents", d, pexp[j]);
    end
    bus_stop;

    // R5: data cut off by repeated START is dropped
    bus_start; tx_byte(DEVW, k); tx_byte(8'h30, k); tx_byte(8'h99, k);
    bus_start; tx_byte(DEVW, k); bus_stop;
    tick(8);
    chk(busy == 0, "R5 no cycle after aborted write", busy, 0);
    rand_read(8'h30, d);
    chk(d == 8'h00, "R5 memory unchanged", d, 0);

    // R2: foreign address
    bus_start; tx_byte(8'hA2, k);
    chk(!k, "R2 foreign address not acknowledged", k, 0);
    tx_byte(8'h40, k); tx_byte(8'h55, k); bus_stop;
    tick(8);
    chk(busy == 0, "R2 foreign write ignored", busy, 0);
    rand_read(8'h40, d);
    chk(d == 8'h00, "R2 memory unchanged", d, 0);

    // R1: START in the middle of a byte
    bus_start;
    for (int i = 0; i < 4; i++) tx_bit(i[0]);
    rand_read(8'h10, d);
    chk(d == 8'h3C, "R1 recovery after mid-byte START", d, 8'h3C);

    // R10: hold aborts a write in flight
    bus_start; tx_byte(DEVW, k); tx_byte(8'h50, k); tx_byte(8'h77, k);
    for (int i = 0; i < 4; i++) tx_bit(1'b0);
    hold = 1; tick(4); hold = 0;
    for (int i = 0; i < 4; i++) tx_bit(1'b1);
    rx_bit(d[0]);
    bus_stop;
    tick(8);
    chk(busy == 0, "R10 aborted write starts no cycle", busy, 0);
    rand_read(8'h50, d);
    chk(d == 8'h00, "R10 aborted write leaves memory", d, 0);

    // R10: no acknowledge while held
    hold = 1;
    bus_start; tx_byte(DEVW, k); bus_stop;
    chk(!k, "R10 no acknowledge while held", k, 0);
    hold = 0;

    // R10: running cycle completes under hold
    bus_start; tx_byte(DEVW, k); tx_byte(8'h60, k); tx_byte(8'h5A, k); bus_stop;
    hold = 1;
    wait_ready;
    chk(last_len == W, "R10 cycle completes under hold", last_len, W);
    hold = 0;
    tick(4);
    rand_read(8'h60, d);
    chk(d == 8'h5A, "R10 memory updated by held cycle", d, 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule